// File: doc/BRIEF.md
# Receive Blanking Filter

This block turns the receive comparator level of a single-wire CAN node into the receive-data pin that the protocol controller samples. The comparator level is first brought into the clock domain. In any active mode it is then forwarded with a fixed latency. A logic 1 means a recessive bus. A logic 0 means a dominant bus, at either the normal or the raised wake-up voltage.

When the node releases its own transmit line (a low-to-high step on the transmit input), the bus rings for a while as it settles. The block masks the receive path for a programmable window of clock cycles after every such release. During the window the receive pin keeps the value it had just before the window opened. A further release inside the window starts a fresh window.

In sleep the receive pin is undriven, and bus traffic is not passed on. The one exception is a wake-up interrupt request. That request makes the pin drive a low level and hold it until the node leaves sleep.

Top module: `rxBlankFilter`

## Requirements
- R1: In an active mode (sleep low) with no blanking window open, a change of the comparator input appears on the receive output after exactly SYNC_STAGES+1 clock edges (3 with the default of 2). The output is 1 for a recessive bus and 0 for a dominant bus.
- R2: When the transmit input is sampled high at an edge after being sampled low at the previous edge, the receive output keeps its prior value for that edge and the following BLANK_CYCLES-1 edges, whatever the comparator does. At the next edge it again takes the synchronised comparator level.
- R3: A new low-to-high transmit step inside an open window restarts the window, so the output is held for BLANK_CYCLES edges counted from the newest step.
- R4: A high-to-low transmit step opens no window. The comparator level still reaches the output with the latency of R1.
- R5: While sleep is high and no wake-up is pending, the output-enable is 0 and the receive output rests at 1 from the first edge after sleep is raised. Comparator activity has no effect on either output.
- R6: A wake-up request sampled while sleep is high makes the output-enable 1 and the receive output 0 from the next edge. Both stay that way after the request is removed, until sleep falls. A later sleep period starts with no pending wake-up.
- R7: At the first edge with sleep low, the output-enable becomes 1 and the receive output takes the synchronised comparator level, unless a blanking window is open.
- R8: During reset the receive output is 1 and the output-enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset, asynchronous assertion |
| busLevelIn | input | 1 | Comparator output, 1 = recessive, 0 = dominant; asynchronous |
| txdIn | input | 1 | Transmit data from the controller, 1 = recessive; synchronous to clk |
| sleepIn | input | 1 | 1 while the node is in sleep mode |
| wakeIrqIn | input | 1 | Wake-up interrupt request from the wake detector |
| rxdOut | output | 1 | Receive data to the controller |
| rxdOe | output | 1 | Drive enable for the receive pin; 0 = pin undriven |

## Verification
The bench builds the block with BLANK_CYCLES set to 6 and the default two synchroniser stages. With this setting the last masked edge and the first released edge of a window are only a few cycles apart, so both can be checked exactly. A restart placed inside the window then lands after the point where the first window would have ended. With the same setting, comparator ringing toggles during the window and settles in time for the first released edge. The sleep, wake-up and exit sequences are then run under fixed latency against the same output register.

// File: rtl/rxbPkg.sv
package rxbPkg;

  // Strobes from the control to the output datapath; at most one of the
  // three update strobes is high in any cycle.
  typedef struct packed {
    logic loadBus;   // copy synchronised bus level to the output
    logic forceLow;  // drive the wake-up interrupt level
    logic parkIdle;  // sleep without wake: rest the output at recessive
    logic driveEn;   // output-enable for the next cycle
  } rxbStrobe_t;

endpackage

// File: rtl/rxbSync.sv
module rxbSync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic qOut
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= dIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], dIn};
      end
    end
  endgenerate

  assign qOut = chain[STAGES-1];

endmodule

// File: rtl/rxbCtrl.sv
module rxbCtrl
  import rxbPkg::*;
#(
  parameter int BLANK_CYCLES = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txdIn,
  input  logic       sleepIn,
  input  logic       wakeIrqIn,
  output rxbStrobe_t strobes
);

  localparam int CNT_W = $clog2(BLANK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BLANK_CYCLES - 1);

  logic             txdPrev;
  logic [CNT_W-1:0] blankCnt;
  logic             wakePend;
  logic             txdRise;
  logic             blanking;
  logic             wakeNow;

  assign txdRise  = txdIn & ~txdPrev;
  assign blanking = txdRise | (blankCnt != '0);
  assign wakeNow  = sleepIn & (wakeIrqIn | wakePend);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txdPrev  <= 1'b1;
      blankCnt <= '0;
      wakePend <= 1'b0;
    end else begin
      txdPrev <= txdIn;
      if (txdRise)
        blankCnt <= CNT_LOAD;
      else if (blankCnt != '0)
        blankCnt <= blankCnt - 1'b1;
      wakePend <= sleepIn & (wakePend | wakeIrqIn);
    end
  end

  always_comb begin
    strobes.forceLow = wakeNow;
    strobes.parkIdle = sleepIn & ~wakeNow;
    strobes.loadBus  = ~sleepIn & ~blanking;
    strobes.driveEn  = ~sleepIn | wakeNow;
  end

  // R5: quiet sleep never asks for the pin to be driven
  p_sleep_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sleepIn && !wakeIrqIn && !wakePend) |-> !strobes.driveEn);

  // R6: a pending wake-up keeps forcing the low level while asleep
  p_wake_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sleepIn && wakeIrqIn) ##1 sleepIn |-> strobes.forceLow);

  // R2: the counter never exceeds its load value
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    blankCnt <= CNT_LOAD);

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadBus, strobes.forceLow, strobes.parkIdle}));

endmodule

// File: rtl/rxbDatapath.sv
module rxbDatapath
  import rxbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSync,
  input  rxbStrobe_t strobes,
  output logic       rxdOut,
  output logic       rxdOe
);

  logic rxdQ;
  logic oeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxdQ <= 1'b1;
      oeQ  <= 1'b0;
    end else begin
      oeQ <= strobes.driveEn;
      if (strobes.forceLow)
        rxdQ <= 1'b0;
      else if (strobes.parkIdle)
        rxdQ <= 1'b1;
      else if (strobes.loadBus)
        rxdQ <= busSync;
    end
  end

  assign rxdOut = rxdQ;
  assign rxdOe  = oeQ;

  // R2: with no update strobe the output holds its value
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadBus || strobes.forceLow || strobes.parkIdle) |=> $stable(rxdOut));

  // R6: wake interrupt is a driven low
  p_wake_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.forceLow |=> (rxdOe && !rxdOut));

  // R5: parked output is undriven and recessive
  p_park_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.parkIdle |=> (!rxdOe && rxdOut));

endmodule

// File: rtl/rxBlankFilter.sv
module rxBlankFilter
  import rxbPkg::*;
#(
  parameter int BLANK_CYCLES = 100,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic busLevelIn,
  input  logic txdIn,
  input  logic sleepIn,
  input  logic wakeIrqIn,
  output logic rxdOut,
  output logic rxdOe
);

  rxbStrobe_t strobes;
  logic       busSync;

  rxbSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (busLevelIn),
    .qOut (busSync)
  );

  rxbCtrl #(.BLANK_CYCLES(BLANK_CYCLES)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txdIn     (txdIn),
    .sleepIn   (sleepIn),
    .wakeIrqIn (wakeIrqIn),
    .strobes   (strobes)
  );

  rxbDatapath i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .busSync (busSync),
    .strobes (strobes),
    .rxdOut  (rxdOut),
    .rxdOe   (rxdOe)
  );

  // R2: the edge that sees a transmit release does not move the output
  p_blank_on_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(txdIn) && $past(rstN) && !sleepIn) |=> $stable(rxdOut));

  // R7: any active mode drives the pin
  p_active_drive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !sleepIn |=> rxdOe);

endmodule

// File: tb/test_rxBlankFilter.sv
module test_rxBlankFilter;

  localparam int BLANK = 6;

  logic clk = 1'b0;
  logic rstN;
  logic busLevelIn;
  logic txdIn;
  logic sleepIn;
  logic wakeIrqIn;
  logic rxdOut;
  logic rxdOe;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #10ns clk = ~clk;

  rxBlankFilter #(.BLANK_CYCLES(BLANK), .SYNC_STAGES(2)) i_rxBlankFilter (
    .clk        (clk),
    .rstN       (rstN),
    .busLevelIn (busLevelIn),
    .txdIn      (txdIn),
    .sleepIn    (sleepIn),
    .wakeIrqIn  (wakeIrqIn),
    .rxdOut     (rxdOut),
    .rxdOe      (rxdOe)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0; txdIn = 1'b1; busLevelIn = 1'b1; sleepIn = 1'b0; wakeIrqIn = 1'b0;
    step(); step(); step();
    check("R8", "rxd in reset", rxdOut, 1'b1);
    check("R8", "oe in reset", rxdOe, 1'b0);
    rstN = 1'b1;
    step();
    check("R7", "oe after reset", rxdOe, 1'b1);
    check("R7", "rxd after reset", rxdOut, 1'b1);
  endtask

  task automatic testPass();
    busLevelIn = 1'b0;
    step(); check("R1", "latency edge1", rxdOut, 1'b1);
    step(); check("R1", "latency edge2", rxdOut, 1'b1);
    step(); check("R1", "dominant edge3", rxdOut, 1'b0);
    busLevelIn = 1'b1;
    step(); step();
    check("R1", "recessive edge2", rxdOut, 1'b0);
    step(); check("R1", "recessive edge3", rxdOut, 1'b1);
  endtask

  task automatic testFallNoBlank();
    txdIn = 1'b0; busLevelIn = 1'b0;
    step(); step();
    check("R4", "fall edge2", rxdOut, 1'b1);
    step(); check("R4", "fall edge3 no blank", rxdOut, 1'b0);
  endtask

  task automatic testBlank();
    // txd low, rxd 0; release transmit while bus rings
    txdIn = 1'b1; busLevelIn = 1'b1;
    for (int k = 1; k <= BLANK; k++) begin
      step();
      check("R2", $sformatf("held edge %0d", k), rxdOut, 1'b0);
      if (k <= BLANK - 3) busLevelIn = (k % 2 == 1) ? 1'b0 : 1'b1;
      else                busLevelIn = 1'b1;
    end
    step();
    check("R2", "released edge", rxdOut, 1'b1);
  endtask

  task automatic testRestart();
    txdIn = 1'b0; busLevelIn = 1'b0;
    step(); step(); step();
    check("R3", "setup dominant", rxdOut, 1'b0);
    txdIn = 1'b1; busLevelIn = 1'b1;
    step(); step(); step();
    txdIn = 1'b0;
    step();
    txdIn = 1'b1;
    step();
    check("R3", "held at second rise", rxdOut, 1'b0);
    for (int k = 1; k < BLANK; k++) begin
      step();
      check("R3", $sformatf("restarted hold %0d", k), rxdOut, 1'b0);
    end
    step();
    check("R3", "released after restart", rxdOut, 1'b1);
  endtask

  task automatic testSleep();
    sleepIn = 1'b1; busLevelIn = 1'b0;
    step();
    check("R5", "oe off in sleep", rxdOe, 1'b0);
    check("R5", "rxd parked", rxdOut, 1'b1);
    for (int k = 0; k < 4; k++) begin
      busLevelIn = ~busLevelIn;
      step();
      check("R5", "bus ignored oe", rxdOe, 1'b0);
      check("R5", "bus ignored rxd", rxdOut, 1'b1);
    end
  endtask

  task automatic testWake();
    wakeIrqIn = 1'b1;
    step();
    check("R6", "wake oe", rxdOe, 1'b1);
    check("R6", "wake low", rxdOut, 1'b0);
    wakeIrqIn = 1'b0; busLevelIn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      check("R6", "wake held low", rxdOut, 1'b0);
    end
    check("R6", "wake held oe", rxdOe, 1'b1);
  endtask

  task automatic testExit();
    sleepIn = 1'b0;
    step();
    check("R7", "exit oe", rxdOe, 1'b1);
    check("R7", "exit rxd bus", rxdOut, 1'b1);
    sleepIn = 1'b1;
    step(); step();
    check("R6", "no stale wake oe", rxdOe, 1'b0);
    check("R6", "no stale wake rxd", rxdOut, 1'b1);
    busLevelIn = 1'b0;
    step(); step();
    sleepIn = 1'b0;
    step();
    check("R7", "exit takes dominant", rxdOut, 1'b0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    testReset();
    testPass();
    testFallNoBlank();
    testBlank();
    testRestart();
    testSleep();
    testWake();
    testExit();
    finish();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

endmodule